// File: doc/BRIEF.md
# PWM Duty-Cycle Current Decoder

This block sits on the controller side of a phase-current sensor. The sensor reports each current sample as the width of an active-low pulse, and it is clocked by a synchronisation square wave that this block also receives. The block runs on the system clock. It times every half-period of the sync wave and the low time of the pulse within it. It divides one by the other and turns the resulting duty into a signed current code.

Each sync transition ends one measurement cycle and starts the next. The low time measured in a cycle is divided by the length of the cycle before it. A cycle begun by a rising sync edge belongs to the first channel, and one begun by a falling edge belongs to the second. Each channel has its own offset input, so the two halves of an uneven sync wave never mix. An averaging mode can be enabled to blend each result with the one before it. If the sync wave stops, the block reports the fault with a flagged sample and restarts its measurement.

Top module: `duty_current_decoder`

## Requirements
- R1: While reset is low, and after reset until the first sample, `cur_valid`, `cur_out` and `range_err` are all zero.
- R2: Every transition of the synchronised `sync_in` is a cycle boundary. The first two boundaries after reset or after a timeout produce no sample. Each later boundary produces exactly one sample.
- R3: The period P of a cycle is the number of clock cycles between its two boundaries. Its low time L is the number of those clock cycles in which the synchronised `pulse_n_in` is 0. The duty for cycle n is floor(32768 · L(n+1) / P(n)), saturated at 65535.
- R4: A sample carries the channel of cycle n. `cur_chan` is 1 when cycle n began with a rising sync edge, and `ofs_ch1` is subtracted from it. `cur_chan` is 0 when cycle n began with a falling edge, and `ofs_ch2` is subtracted.
- R5: The raw code is 4 · (6554 − duty) − offset, as a signed 20-bit value. A duty of 20 % (6554) with zero offset gives 0, and a lower duty gives a positive code.
- R6: `range_err` is 1 on a sample whose duty is below 2621 or above 10486. Such a sample is still strobed by `cur_valid`.
- R7: If a started cycle reaches 65535 clock cycles without a boundary, one sample is strobed with `cur_out` = 0, `range_err` = 1 and the stalled cycle's channel. Measurement then restarts as after reset.
- R8: With `avg_en` high, `cur_out` is floor((raw(n) + raw(n−1)) / 2). The first sample after reset or after a timeout is passed on unaveraged.
- R9: `cur_valid` is a single-cycle pulse, with one pulse per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Sync square wave, asynchronous |
| pulse_n_in | input | 1 | Active-low sensor pulse, asynchronous |
| avg_en | input | 1 | Average each sample with the previous one |
| ofs_ch1 | input | 16 | Signed offset for the channel of rising-edge cycles |
| ofs_ch2 | input | 16 | Signed offset for the channel of falling-edge cycles |
| cur_out | output | 20 | Signed current code |
| cur_valid | output | 1 | One-cycle strobe for a new sample |
| cur_chan | output | 1 | Channel of the sample (1 = rising-edge cycle) |
| range_err | output | 1 | Duty out of range, or sync timeout |

## Verification
Several properties are checked on every cycle:
- the low-time count never exceeds the period count;
- no division is requested with a zero period or while the divider is still busy;
- the strobe never lasts two cycles;
- a timeout always appears on the outputs as a zero, flagged sample.

The arithmetic can only be shown by the bench's scenarios, which compare against an independent model. This covers pairing each low time with the previous period, keeping the channels and their offsets apart when the sync halves are unequal, the range limits at exactly 8 % and just above 32 %, quotient saturation, averaging, and the restart after a sync stall.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants helper for the duty-cycle current decoder.
// Assumes duties are fixed-point fractions with 'frac' fraction bits.
package dcd_pkg;
    // Converts a duty given in per-mille to the nearest fixed-point code.
    function automatic int duty_code(input int per_mille, input int frac);
        longint scaled;
        scaled = (longint'(per_mille) * (longint'(1) << frac) + 500) / 1000;
        return int'(scaled);
    endfunction
endpackage

// File: rtl/dcd_input_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchroniser for the sync wave and the active-low pulse,
// plus transition detection on the synchronised sync wave.
// Assumes both inputs are asynchronous to clk; both see the same latency,
// so period and low-time counts stay aligned.
module dcd_input_sync #(
    parameter int WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    input  logic pulse_n_raw,
    output logic sync_lvl,
    output logic sync_edge,
    output logic pulse_low
);
    localparam int SYNC_BIT  = 0;
    localparam int PULSE_BIT = 1;

    logic [WIDTH-1:0] raw;
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] safe_q;
    logic             sync_last_q;

    assign raw = {pulse_n_raw, sync_raw};

    // Per-bit two-stage synchroniser chain; pulse idles high.
    for (genvar b = 0; b < WIDTH; b++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[b] <= (b == PULSE_BIT);
                safe_q[b] <= (b == PULSE_BIT);
            end else begin
                meta_q[b] <= raw[b];
                safe_q[b] <= meta_q[b];
            end
        end
    end

    // Remembers the previous synchronised sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_last_q <= 1'b0;
        else        sync_last_q <= safe_q[SYNC_BIT];
    end

    assign sync_lvl  = safe_q[SYNC_BIT];
    assign sync_edge = safe_q[SYNC_BIT] ^ sync_last_q;
    assign pulse_low = ~safe_q[PULSE_BIT];
endmodule

// File: rtl/dcd_cycle_timer.sv
`timescale 1ns/1ps
// Module: times each sync half-period and the pulse low time within it,
// and pairs the low time of one cycle with the period of the cycle before.
// Issues a division request per boundary once two full cycles are known;
// reports a timeout when a started cycle saturates the period counter.
module dcd_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_edge,
    input  logic             sync_lvl,
    input  logic             pulse_low,
    output logic             req,
    output logic [CNT_W-1:0] req_low,
    output logic [CNT_W-1:0] req_per,
    output logic             req_chan,
    output logic             tout,
    output logic             tout_chan
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_cnt, low_cnt, per_prev;
    logic             chan_cur, chan_prev, have_cycle, have_prev;

    // Counts, boundary bookkeeping, request and timeout generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt    <= '0;
            low_cnt    <= '0;
            per_prev   <= '0;
            chan_cur   <= 1'b0;
            chan_prev  <= 1'b0;
            have_cycle <= 1'b0;
            have_prev  <= 1'b0;
            req        <= 1'b0;
            req_low    <= '0;
            req_per    <= '0;
            req_chan   <= 1'b0;
            tout       <= 1'b0;
            tout_chan  <= 1'b0;
        end else begin
            req  <= 1'b0;
            tout <= 1'b0;
            if (sync_edge) begin
                if (have_prev) begin
                    req      <= 1'b1;
                    req_low  <= low_cnt;
                    req_per  <= per_prev;
                    req_chan <= chan_prev;
                end
                if (have_cycle) begin
                    per_prev  <= per_cnt;
                    chan_prev <= chan_cur;
                    have_prev <= 1'b1;
                end
                have_cycle <= 1'b1;
                chan_cur   <= sync_lvl;
                per_cnt    <= CNT_ONE;
                low_cnt    <= pulse_low ? CNT_ONE : '0;
            end else begin
                if (per_cnt != CNT_MAX) per_cnt <= per_cnt + CNT_ONE;
                if (pulse_low && low_cnt != CNT_MAX) low_cnt <= low_cnt + CNT_ONE;
                if (have_cycle && per_cnt == CNT_MAX) begin
                    tout       <= 1'b1;
                    tout_chan  <= chan_cur;
                    have_cycle <= 1'b0;
                    have_prev  <= 1'b0;
                end
            end
        end
    end

    AST_LOW_LE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= per_cnt); // R3
    AST_REQ_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (req_per != '0)); // R3
endmodule

// File: rtl/dcd_divider.sv
`timescale 1ns/1ps
// Module: serial restoring divider, one quotient bit per clock.
// Computes floor((num << FRAC) / den) and saturates it to Q_W bits.
// Assumes den is non-zero and start only arrives while idle.
module dcd_divider #(
    parameter int CNT_W = 16,
    parameter int FRAC  = 15,
    parameter int Q_W   = FRAC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] num,
    input  logic [CNT_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quot
);
    localparam int NQ    = CNT_W + FRAC;
    localparam int STP_W = $clog2(NQ + 1);
    localparam logic [STP_W-1:0] STEPS = STP_W'(NQ);

    logic             busy;
    logic [STP_W-1:0] steps_left;
    logic [CNT_W-1:0] rem_q, den_q;
    logic [NQ-1:0]    dvd_q, quo_q;
    logic [CNT_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, dvd_q[NQ-1]};
    assign fits  = trial >= {1'b0, den_q};

    // Loads operands on start, then shifts out one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            steps_left <= '0;
            rem_q      <= '0;
            den_q      <= '0;
            dvd_q      <= '0;
            quo_q      <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy       <= 1'b1;
                steps_left <= STEPS;
                rem_q      <= '0;
                den_q      <= den;
                dvd_q      <= {num, {FRAC{1'b0}}};
                quo_q      <= '0;
            end else if (busy) begin
                rem_q      <= fits ? CNT_W'(trial - {1'b0, den_q}) : trial[CNT_W-1:0];
                dvd_q      <= dvd_q << 1;
                quo_q      <= {quo_q[NQ-2:0], fits};
                steps_left <= steps_left - 1'b1;
                if (steps_left == STP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = (|quo_q[NQ-1:Q_W]) ? '1 : quo_q[Q_W-1:0];

    AST_DIV_IDLE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R2
endmodule

// File: rtl/duty_current_decoder.sv
`timescale 1ns/1ps
// Module: top of the duty-cycle current decoder. Converts the measured duty
// of an active-low sensor pulse into a signed, per-channel offset-corrected
// current code with optional two-sample averaging and a range-error flag.
// Assumes each sync half-period is longer than the divider latency.
module duty_current_decoder #(
    parameter int CNT_W      = 16,
    parameter int FRAC       = 15,
    parameter int GAIN_SHIFT = 2,
    parameter int OFS_W      = 16,
    parameter int OUT_W      = FRAC + 1 + GAIN_SHIFT + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_in,
    input  logic                    pulse_n_in,
    input  logic                    avg_en,
    input  logic signed [OFS_W-1:0] ofs_ch1,
    input  logic signed [OFS_W-1:0] ofs_ch2,
    output logic signed [OUT_W-1:0] cur_out,
    output logic                    cur_valid,
    output logic                    cur_chan,
    output logic                    range_err
);
    localparam int Q_W = FRAC + 1;
    localparam logic signed [OUT_W-1:0] MID_S = OUT_W'(dcd_pkg::duty_code(200, FRAC));
    localparam logic [Q_W-1:0] LO_Q = Q_W'(dcd_pkg::duty_code(80, FRAC));
    localparam logic [Q_W-1:0] HI_Q = Q_W'(dcd_pkg::duty_code(320, FRAC));

    logic             s_lvl, s_edge, p_low;
    logic             req, req_chan, tout, tout_chan, div_done;
    logic [CNT_W-1:0] req_low, req_per;
    logic [Q_W-1:0]   duty;
    logic             pend_chan, hist_ok;
    logic signed [OUT_W-1:0] hist, raw, ofs_ext, blended;
    logic signed [OUT_W:0]   pair_sum;

    dcd_input_sync #(.WIDTH(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .sync_raw(sync_in), .pulse_n_raw(pulse_n_in),
        .sync_lvl(s_lvl), .sync_edge(s_edge), .pulse_low(p_low));

    dcd_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .sync_edge(s_edge), .sync_lvl(s_lvl),
        .pulse_low(p_low), .req(req), .req_low(req_low), .req_per(req_per),
        .req_chan(req_chan), .tout(tout), .tout_chan(tout_chan));

    dcd_divider #(.CNT_W(CNT_W), .FRAC(FRAC), .Q_W(Q_W)) i_div (
        .clk(clk), .rst_n(rst_n), .start(req), .num(req_low), .den(req_per),
        .done(div_done), .quot(duty));

    // Raw code: inverse duty map about the 20 % midpoint, minus channel offset.
    always_comb begin
        ofs_ext  = pend_chan ? OUT_W'(ofs_ch1) : OUT_W'(ofs_ch2);
        raw      = ((MID_S - $signed({{(OUT_W-Q_W){1'b0}}, duty})) <<< GAIN_SHIFT) - ofs_ext;
        pair_sum = {raw[OUT_W-1], raw} + {hist[OUT_W-1], hist};
        blended  = (avg_en && hist_ok) ? pair_sum[OUT_W:1] : raw;
    end

    // Holds the channel of the division in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_chan <= 1'b0;
        else if (req) pend_chan <= req_chan;
    end

    // Output register, averaging history and timeout reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_out   <= '0;
            cur_valid <= 1'b0;
            cur_chan  <= 1'b0;
            range_err <= 1'b0;
            hist      <= '0;
            hist_ok   <= 1'b0;
        end else begin
            cur_valid <= 1'b0;
            if (tout) begin
                cur_valid <= 1'b1;
                cur_out   <= '0;
                cur_chan  <= tout_chan;
                range_err <= 1'b1;
                hist_ok   <= 1'b0;
            end else if (div_done) begin
                cur_valid <= 1'b1;
                cur_out   <= blended;
                cur_chan  <= pend_chan;
                range_err <= (duty < LO_Q) || (duty > HI_Q);
                hist      <= raw;
                hist_ok   <= 1'b1;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |=> !cur_valid); // R9
    AST_TIMEOUT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        tout |=> (cur_valid && range_err && cur_out == '0)); // R7
endmodule

// File: tb/test_duty_current_decoder.sv
`timescale 1ns/1ps
// Bench: a driver pushes expected samples into a scoreboard queue as it
// creates each sync boundary; a monitor pops and compares on every strobe.
module test_duty_current_decoder;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    code;
        bit    chan;
        bit    err;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic pulse_n_in = 1'b1;
    logic avg_en = 1'b0;
    logic signed [15:0] ofs_ch1 = '0;
    logic signed [15:0] ofs_ch2 = '0;
    logic signed [19:0] cur_out;
    logic cur_valid, cur_chan, range_err;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    // Model state for the driver.
    int bnd = 0;
    int cur_p = 0, cur_l = 0, prev_p = 0;
    bit cur_ch = 0, prev_ch = 0, lvl = 0;
    int hist = 0;
    bit hist_ok = 0;

    duty_current_decoder i_duty_current_decoder (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .pulse_n_in(pulse_n_in),
        .avg_en(avg_en), .ofs_ch1(ofs_ch1), .ofs_ch2(ofs_ch2),
        .cur_out(cur_out), .cur_valid(cur_valid), .cur_chan(cur_chan),
        .range_err(range_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Builds the expected sample for low time l over period p on channel ch.
    task automatic push_sample(input int l, input int p, input bit ch, input string tag);
        longint q;
        int raw;
        exp_t e;
        q = (longint'(l) * 32768) / p;
        if (q > 65535) q = 65535;
        raw = 4 * (6554 - int'(q)) - (ch ? int'(ofs_ch1) : int'(ofs_ch2));
        e.err  = (q < 2621) || (q > 10486);
        e.code = (avg_en && hist_ok) ? int'((longint'(raw) + hist) >>> 1) : raw;
        e.chan = ch;
        e.tag  = tag;
        hist = raw;
        hist_ok = 1;
        sb.push_back(e);
    endtask

    // One sync half-cycle of p clocks with the pulse low for its first l clocks.
    task automatic half(input int p, input int l, input string tag);
        lvl = ~lvl;
        if (bnd >= 2) push_sample(cur_l, prev_p, prev_ch, tag);
        if (bnd >= 1) begin
            prev_p  = cur_p;
            prev_ch = cur_ch;
        end
        cur_p = p; cur_l = l; cur_ch = lvl; bnd++;
        for (int i = 0; i < p; i++) begin
            if (i == 0) sync_in = lvl;
            pulse_n_in = (i < l) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
    endtask

    // Holds sync still long enough for the timeout sample (R7).
    task automatic stall(input int n);
        exp_t e;
        e.code = 0; e.chan = cur_ch; e.err = 1; e.tag = "R7";
        sb.push_back(e);
        hist_ok = 0;
        bnd = 0;
        pulse_n_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each strobed sample against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && cur_valid) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected sample", int'(cur_out), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(cur_out) == e.code, {e.tag, " code"}, int'(cur_out), e.code);
                check(cur_chan == e.chan, {e.tag, " R4 chan"}, int'(cur_chan), int'(e.chan));
                check(range_err == e.err, {e.tag, " R6 err"}, int'(range_err), int'(e.err));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cur_valid == 0, "R1 valid", int'(cur_valid), 0);
        check(cur_out == 0, "R1 out", int'(cur_out), 0);
        check(range_err == 0, "R1 err", int'(range_err), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(cur_valid == 0, "R1 idle", int'(cur_valid), 0);

        // R2 R3 R5: symmetric sync, several duties.
        half(200, 40, "R2"); half(200, 40, "R2"); half(200, 40, "R5");
        half(200, 20, "R3"); half(200, 60, "R5"); half(200, 30, "R3");
        half(200, 50, "R5");
        // R3 R4: unequal sync halves pair low time with the previous period.
        half(150, 30, "R4"); half(250, 50, "R3"); half(150, 45, "R4");
        half(250, 25, "R3");
        // R4: distinct per-channel offsets.
        ofs_ch1 = 16'sd100; ofs_ch2 = -16'sd37;
        half(150, 30, "R4"); half(250, 60, "R4"); half(150, 20, "R4");
        // R6: range limits; 16/200 sits exactly at 8 %, 65/200 just above 32 %.
        half(200, 10, "R6"); half(200, 70, "R6"); half(200, 16, "R6");
        half(200, 64, "R6"); half(200, 65, "R6"); half(150, 40, "R6");
        // R3: low time twice the previous period saturates the duty.
        half(350, 300, "R3"); half(200, 40, "R3");
        // R8: averaging of consecutive samples.
        avg_en = 1'b1;
        half(200, 20, "R8"); half(200, 60, "R8"); half(300, 50, "R8");
        half(200, 45, "R8");
        // R7: sync stops; flagged zero sample, then a restart.
        stall(66000);
        ofs_ch1 = 16'sd0; ofs_ch2 = 16'sd12;
        half(200, 40, "R7"); half(200, 40, "R7"); half(200, 30, "R8");
        half(200, 50, "R8"); half(200, 40, "R9");
        repeat (100) @(negedge clk);
        check(sb.size() == 0, "R2 missing samples", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule